// File: doc/BRIEF.md
# Lane-Restricted Byte Permute Unit

This block rearranges the bytes of a vector operand. A control vector of the same width supplies one control byte for every result byte. That control byte names which source byte is copied into the position, or it forces the position to zero. Selection never crosses a 16-byte lane, so a 512-bit operation acts as four independent 128-bit permutes side by side.

The unit serves an execution pipeline and supports five operation forms:

- Two legacy forms (64-bit and 128-bit) permute the old destination value in place. They keep every destination bit above the operation width.
- Three three-operand forms (128, 256 and 512 bits) read a separate data operand. They clear everything above the width. An optional per-byte write mask either merges the old destination byte or writes zero into the positions it leaves out.

The result is registered and appears one clock after the request, qualified by a valid flag.

Top module: `bshuf_unit`

## Requirements
- R1: When bit 7 of a control byte is 1, the result byte at that position is 0x00, whatever the other control bits are (for every form and every byte that is written).
- R2: In the 128-bit and wider forms, bits 3:0 of a control byte select the source byte, and bits 6:4 have no effect.
- R3: Form code 0 (64-bit legacy) permutes bytes 0..7 of `old_dst` using only bits 2:0 of each control byte. Result bits 511:64 equal `old_dst` bits 511:64. Byte i occupies bits 8i+7:8i in every vector.
- R4: Result byte 16*L+p can only take a byte from lane L of the data operand, that is byte 16*L+index.
- R5: Form code 1 (128-bit legacy) takes its data from `old_dst`, not `src_vec`. All selections read the value from before the operation, and result bits 511:128 equal `old_dst` bits 511:128.
- R6: Form codes 2 (128-bit) and 3 (256-bit) clear every result bit above 127 and above 255 respectively. Form code 4 is 512-bit.
- R7: In forms 2..4 with `mask_en`=1 and `zero_mode`=0, a byte whose `wmask` bit is 0 keeps its `old_dst` byte.
- R8: In forms 2..4 with `mask_en`=1 and `zero_mode`=1, a byte whose `wmask` bit is 0 becomes 0x00.
- R9: With `mask_en`=0 every byte in the width is written as if its mask bit were 1. The legacy forms (codes 0 and 1) ignore `mask_en`, `zero_mode` and `wmask`.
- R10: Form codes 5, 6 and 7 give an all-zero result.
- R11: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and `result` holds its value when `in_valid` is low.
- R12: Active-low `rst_n` clears `out_valid` and `result` asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe; operands are captured this cycle |
| op_size | input | 3 | Form code: 0 legacy 64, 1 legacy 128, 2 128-bit, 3 256-bit, 4 512-bit |
| mask_en | input | 1 | Apply the per-byte write mask (forms 2..4) |
| zero_mode | input | 1 | 1: unmasked bytes become zero; 0: they keep `old_dst` |
| wmask | input | 64 | Per-byte write mask, bit i for byte i |
| ctrl_vec | input | 512 | Control bytes |
| src_vec | input | 512 | Data operand of the three-operand forms |
| old_dst | input | 512 | Previous destination value; data operand of legacy forms |
| out_valid | output | 1 | Result valid |
| result | output | 512 | Registered permute result |

## Verification
On every cycle, the assertions check the valid timing, result hold, zero forcing by bit 7, zeroing and merging of masked-off bytes, clearing or keeping of the bits above the width, and the zero result of illegal codes. Only the bench scenarios can show which byte a given index actually selects:

- that bits 6:4 of a control byte are ignored;
- that lanes stay isolated;
- that the legacy in-place forms read the value from before the operation when the permutation is reversed;
- the known 64-bit vector.

// File: rtl/bshuf_pkg.sv
package bshuf_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    FORM_L64  = 3'd0,
    FORM_L128 = 3'd1,
    FORM_V128 = 3'd2,
    FORM_V256 = 3'd3,
    FORM_V512 = 3'd4
  } form_e;

  // number of bytes covered by a form, 0 for an illegal code
  function automatic logic [7:0] form_bytes(logic [2:0] code);
    case (code)
      FORM_L64:             form_bytes = 8'd8;
      FORM_L128, FORM_V128: form_bytes = 8'd16;
      FORM_V256:            form_bytes = 8'd32;
      FORM_V512:            form_bytes = 8'd64;
      default:              form_bytes = 8'd0;
    endcase
  endfunction
endpackage

// File: rtl/bshuf_decode.sv
module bshuf_decode
  import bshuf_pkg::*;
(
  input  logic [2:0] op_size,
  output logic       legal,
  output logic       legacy,
  output logic       narrow,
  output logic [7:0] span_bytes
);
  always_comb begin
    legal      = (op_size <= FORM_V512);
    legacy     = (op_size == FORM_L64) || (op_size == FORM_L128);
    narrow     = (op_size == FORM_L64);
    span_bytes = form_bytes(op_size);
  end
endmodule

// File: rtl/bshuf_lane.sv
module bshuf_lane #(
  parameter int LANE_BYTES  = 16,
  parameter int NARROW_BITS = 3
) (
  input  logic [LANE_BYTES*8-1:0] data,
  input  logic [LANE_BYTES*8-1:0] ctrl,
  input  logic                    narrow,
  output logic [LANE_BYTES*8-1:0] shuf
);
  localparam int IDX_W = $clog2(LANE_BYTES);
  localparam int OFS_W = IDX_W + 3;

  for (genvar b = 0; b < LANE_BYTES; b++) begin : g_byte
    logic [7:0]       cbyte;
    logic [IDX_W-1:0] idx;
    logic [OFS_W-1:0] ofs;
    assign cbyte = ctrl[b*8 +: 8];
    assign idx   = narrow ? {{(IDX_W-NARROW_BITS){1'b0}}, cbyte[NARROW_BITS-1:0]}
                          : cbyte[IDX_W-1:0];
    assign ofs   = {idx, 3'b000};
    assign shuf[b*8 +: 8] = cbyte[7] ? 8'h00 : data[ofs +: 8];
  end
endmodule

// File: rtl/bshuf_merge.sv
module bshuf_merge #(
  parameter int VEC_BYTES = 64
) (
  input  logic [VEC_BYTES*8-1:0] shuf,
  input  logic [VEC_BYTES*8-1:0] old_dst,
  input  logic [VEC_BYTES-1:0]   wmask,
  input  logic                   legal,
  input  logic                   legacy,
  input  logic                   mask_en,
  input  logic                   zero_mode,
  input  logic [7:0]             span_bytes,
  output logic [VEC_BYTES*8-1:0] res
);
  for (genvar i = 0; i < VEC_BYTES; i++) begin : g_byte
    logic in_span;
    logic wr_en;
    logic [7:0] old_b;
    assign in_span = (8'(i) < span_bytes);
    assign wr_en   = legacy | ~mask_en | wmask[i];
    assign old_b   = old_dst[i*8 +: 8];
    always_comb begin
      if (!legal)        res[i*8 +: 8] = 8'h00;
      else if (!in_span) res[i*8 +: 8] = legacy ? old_b : 8'h00;
      else if (wr_en)    res[i*8 +: 8] = shuf[i*8 +: 8];
      else               res[i*8 +: 8] = zero_mode ? 8'h00 : old_b;
    end
  end
endmodule

// File: rtl/bshuf_unit.sv
module bshuf_unit
  import bshuf_pkg::*;
#(
  parameter int NUM_LANES  = 4,
  parameter int LANE_BYTES = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              in_valid,
  input  logic [2:0]                        op_size,
  input  logic                              mask_en,
  input  logic                              zero_mode,
  input  logic [NUM_LANES*LANE_BYTES-1:0]   wmask,
  input  logic [NUM_LANES*LANE_BYTES*8-1:0] ctrl_vec,
  input  logic [NUM_LANES*LANE_BYTES*8-1:0] src_vec,
  input  logic [NUM_LANES*LANE_BYTES*8-1:0] old_dst,
  output logic                              out_valid,
  output logic [NUM_LANES*LANE_BYTES*8-1:0] result
);
  localparam int VEC_BYTES = NUM_LANES * LANE_BYTES;
  localparam int VEC_W     = VEC_BYTES * 8;
  localparam int LANE_W    = LANE_BYTES * 8;

  logic             legal, legacy, narrow;
  logic [7:0]       span_bytes;
  logic [VEC_W-1:0] data_sel, shuf_all, res_comb;
  logic [VEC_W-1:0] result_d, result_q;
  logic             valid_d, valid_q;

  bshuf_decode u_decode (
    .op_size   (op_size),
    .legal     (legal),
    .legacy    (legacy),
    .narrow    (narrow),
    .span_bytes(span_bytes)
  );

  // legacy forms permute the pre-operation destination in place
  assign data_sel = legacy ? old_dst : src_vec;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    bshuf_lane #(.LANE_BYTES(LANE_BYTES), .NARROW_BITS(3)) u_lane (
      .data  (data_sel[l*LANE_W +: LANE_W]),
      .ctrl  (ctrl_vec[l*LANE_W +: LANE_W]),
      .narrow(narrow),
      .shuf  (shuf_all[l*LANE_W +: LANE_W])
    );
  end

  bshuf_merge #(.VEC_BYTES(VEC_BYTES)) u_merge (
    .shuf      (shuf_all),
    .old_dst   (old_dst),
    .wmask     (wmask),
    .legal     (legal),
    .legacy    (legacy),
    .mask_en   (mask_en),
    .zero_mode (zero_mode),
    .span_bytes(span_bytes),
    .res       (res_comb)
  );

  // next-state
  always_comb begin
    valid_d  = in_valid;
    result_d = in_valid ? res_comb : result_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      result_q <= '0;
    end else begin
      valid_q  <= valid_d;
      result_q <= result_d;
    end
  end

  assign out_valid = valid_q;
  assign result    = result_q;

  // ---------------- assertions ----------------
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R11
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R11
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result)); // R11
  AST_BAD_FORM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_size > 3'd4) |=> (result == '0)); // R10

  if (NUM_LANES > 2) begin : g_chk_upper
    AST_LEGACY_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_size == 3'd1) |=> (result[VEC_W-1:128] == $past(old_dst[VEC_W-1:128]))); // R5
    AST_NARROW_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_size == 3'd2) |=> (result[VEC_W-1:128] == '0)); // R6
    AST_MID_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_size == 3'd3) |=> (result[VEC_W-1:256] == '0)); // R6
  end

  for (genvar i = 0; i < VEC_BYTES; i++) begin : g_chk_byte
    AST_MSB_FORCES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && ctrl_vec[i*8+7] && op_size <= 3'd4 && (8'(i) < form_bytes(op_size))
       && (op_size < 3'd2 || !mask_en || wmask[i]))
      |=> (result[i*8 +: 8] == 8'h00)); // R1
    AST_MASK_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_size >= 3'd2 && op_size <= 3'd4 && mask_en && zero_mode && !wmask[i])
      |=> (result[i*8 +: 8] == 8'h00)); // R8
    AST_MASK_MERGES: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_size >= 3'd2 && op_size <= 3'd4 && mask_en && !zero_mode && !wmask[i]
       && (8'(i) < form_bytes(op_size)))
      |=> (result[i*8 +: 8] == $past(old_dst[i*8 +: 8]))); // R7
  end
endmodule

// File: tb/bshuf_unit_test.sv
`timescale 1ns/1ps
module bshuf_unit_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [2:0]   op_size;
  logic         mask_en, zero_mode;
  logic [63:0]  wmask;
  logic [511:0] ctrl_vec, src_vec, old_dst;
  logic         out_valid;
  logic [511:0] result;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  bshuf_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_size(op_size),
    .mask_en(mask_en), .zero_mode(zero_mode), .wmask(wmask),
    .ctrl_vec(ctrl_vec), .src_vec(src_vec), .old_dst(old_dst),
    .out_valid(out_valid), .result(result)
  );

  typedef struct packed {
    logic [3:0]  tag;
    logic [2:0]  op;
    logic        me;
    logic        zm;
    logic [15:0] seed;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{4'd3,  3'd0, 1'b0, 1'b0, 16'd11},  // R3 legacy 64
    '{4'd5,  3'd1, 1'b0, 1'b0, 16'd22},  // R5 legacy 128
    '{4'd9,  3'd1, 1'b1, 1'b1, 16'd33},  // R9 legacy ignores mask
    '{4'd6,  3'd2, 1'b0, 1'b0, 16'd44},  // R6 128 clears upper
    '{4'd6,  3'd3, 1'b0, 1'b0, 16'd55},  // R6 256 clears upper
    '{4'd4,  3'd4, 1'b0, 1'b0, 16'd66},  // R4 512 four lanes
    '{4'd7,  3'd4, 1'b1, 1'b0, 16'd77},  // R7 merge
    '{4'd8,  3'd4, 1'b1, 1'b1, 16'd88},  // R8 zeroing
    '{4'd7,  3'd3, 1'b1, 1'b0, 16'd99},  // R7 merge 256
    '{4'd8,  3'd2, 1'b1, 1'b1, 16'd111}, // R8 zeroing 128
    '{4'd10, 3'd5, 1'b0, 1'b0, 16'd122}, // R10
    '{4'd10, 3'd7, 1'b1, 1'b1, 16'd133}, // R10
    '{4'd1,  3'd4, 1'b0, 1'b1, 16'd144}, // R1 via random bit 7
    '{4'd2,  3'd2, 1'b0, 1'b0, 16'd155}  // R2 random high bits
  };

  function automatic string tag_name(logic [3:0] t);
    case (t)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
      4'd10: return "R10"; 4'd11: return "R11"; default: return "R12";
    endcase
  endfunction

  function automatic logic [511:0] gen(int unsigned seed);
    logic [511:0] v;
    logic [31:0]  x;
    x = seed * 32'd2654435761 + 32'd12345;
    for (int k = 0; k < 16; k++) begin
      x = x * 32'd1664525 + 32'd1013904223;
      v[k*32 +: 32] = x ^ {x[15:0], x[31:16]};
    end
    return v;
  endfunction

  // expected result from the requirements
  function automatic logic [511:0] model(logic [2:0] op, logic me, logic zm,
      logic [63:0] wm, logic [511:0] c, logic [511:0] s, logic [511:0] o);
    logic [511:0] r;
    logic [511:0] d;
    int span;
    logic leg;
    leg  = (op == 3'd0) || (op == 3'd1);
    d    = leg ? o : s;
    span = (op == 3'd0) ? 8 : (op == 3'd1 || op == 3'd2) ? 16 :
           (op == 3'd3) ? 32 : (op == 3'd4) ? 64 : 0;
    for (int i = 0; i < 64; i++) begin
      if (op > 3'd4)                       r[i*8 +: 8] = 8'h00;
      else if (i >= span)                  r[i*8 +: 8] = leg ? o[i*8 +: 8] : 8'h00;
      else if (!leg && me && !wm[i])       r[i*8 +: 8] = zm ? 8'h00 : o[i*8 +: 8];
      else if (c[i*8+7])                   r[i*8 +: 8] = 8'h00;
      else begin
        int idx;
        idx = (op == 3'd0) ? int'(c[i*8 +: 3]) : int'(c[i*8 +: 4]);
        r[i*8 +: 8] = d[((i/16)*16 + idx)*8 +: 8];
      end
    end
    return r;
  endfunction

  task automatic check(string req, logic [511:0] act, logic [511:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_bit(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(logic [2:0] op, logic me, logic zm, logic [63:0] wm,
      logic [511:0] c, logic [511:0] s, logic [511:0] o);
    @(negedge clk);
    op_size = op; mask_en = me; zero_mode = zm; wmask = wm;
    ctrl_vec = c; src_vec = s; old_dst = o; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [511:0] c, s, o, e;
    logic [63:0]  wm;
    rst_n = 1'b0; in_valid = 1'b0; op_size = '0; mask_en = 1'b0; zero_mode = 1'b0;
    wmask = '0; ctrl_vec = '0; src_vec = '0; old_dst = '0;
    repeat (3) @(negedge clk);
    check_bit("R12", out_valid, 1'b0);
    check("R12", result, '0);
    rst_n = 1'b1;

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      c  = gen(VECS[v].seed);
      s  = gen(VECS[v].seed + 1000);
      o  = gen(VECS[v].seed + 2000);
      wm = gen(VECS[v].seed + 3000)[63:0];
      drive(VECS[v].op, VECS[v].me, VECS[v].zm, wm, c, s, o);
      check(tag_name(VECS[v].tag), result,
            model(VECS[v].op, VECS[v].me, VECS[v].zm, wm, c, s, o));
    end

    // R3 and R1: known 64-bit vector, upper destination preserved
    o = gen(7); s = gen(8); c = gen(9);
    c[63:0] = 64'h0707FF80_01000000;
    o[63:0] = 64'h04010703_0202FF01;
    e = o; e[63:0] = 64'h04040000_FF010101;
    drive(3'd0, 1'b1, 1'b1, 64'h0, c, s, o);
    check("R3", result, e);

    // R2: bits 6:4 carry junk, byte i picks byte 15-i
    s = gen(10); o = gen(11); c = '0; e = '0;
    for (int i = 0; i < 16; i++) begin
      c[i*8 +: 8] = {1'b0, 3'(i + 3), 4'(15 - i)};
      e[i*8 +: 8] = s[(15 - i)*8 +: 8];
    end
    drive(3'd2, 1'b0, 1'b0, 64'h0, c, s, o);
    check("R2", result, e);

    // R4: every index is 15, stays inside its own lane
    s = gen(12); o = gen(13);
    for (int i = 0; i < 64; i++) begin
      c[i*8 +: 8] = 8'h0F;
      e[i*8 +: 8] = s[((i/16)*16 + 15)*8 +: 8];
    end
    drive(3'd4, 1'b0, 1'b0, 64'h0, c, s, o);
    check("R4", result, e);

    // R1: bit 7 set everywhere in a 256-bit op
    for (int i = 0; i < 64; i++) c[i*8 +: 8] = 8'h8F;
    drive(3'd3, 1'b0, 1'b0, 64'h0, c, gen(14), gen(15));
    check("R1", result, '0);

    // R5: reversal reads the pre-operation destination, src ignored
    s = gen(16); o = gen(17); c = gen(18); e = o;
    for (int i = 0; i < 16; i++) begin
      c[i*8 +: 8] = 8'(15 - i);
      e[i*8 +: 8] = o[(15 - i)*8 +: 8];
    end
    drive(3'd1, 1'b0, 1'b0, 64'h0, c, s, o);
    check("R5", result, e);

    // R9: mask disabled writes all bytes even with zero mask
    c = gen(19); s = gen(20); o = gen(21);
    drive(3'd4, 1'b0, 1'b1, 64'h0, c, s, o);
    check("R9", result, model(3'd4, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, c, s, o));

    // R11: valid timing and hold
    drive(3'd3, 1'b0, 1'b0, 64'h0, c, s, o);
    check_bit("R11", out_valid, 1'b1);
    e = result;
    ctrl_vec = gen(22); src_vec = gen(23); old_dst = gen(24);
    @(negedge clk);
    check_bit("R11", out_valid, 1'b0);
    @(negedge clk);
    check("R11", result, e);

    // R12: reset mid-run clears state
    drive(3'd4, 1'b0, 1'b0, 64'h0, gen(25), gen(26), gen(27));
    rst_n = 1'b0;
    #1;
    check_bit("R12", out_valid, 1'b0);
    check("R12", result, '0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule